// File: doc/BRIEF.md
# Tuning Synthesizer Reference Divider and Phase Detector

This block is the digital heart of a radio tuning synthesizer. It runs on one system clock. The crystal and the local-oscillator inputs arrive as one-cycle tick enables. A reference divider turns the 75 kHz crystal ticks into one of seven reference rates: 1, 3, 3.125, 5, 6.25, 12.5 or 25 kHz. A programmable divider counts the ticks of the selected local-oscillator path and emits one edge every N ticks. A sequential phase detector compares the two divided edges and drives a charge-pump control.

The pump control is three-state. When the divided local edge leads, the block drives the pump high. When the reference edge leads, it drives the pump low. Otherwise the pump is released. A selectable dead zone suppresses short phase errors. A sticky unlock flag records any pump pulse that got through.

Software loads the divide value and the control fields over a small parallel write port. A run input stops the loop, which covers the halt, backup and stop states. Band decoding also gives registered enables for the external FM and AM input amplifiers.

Top module: `pll_synth_core`

## Requirements
- R1: Control register (write address 1) bits [2:0] select the reference ratio. Codes 0..6 divide the crystal ticks by 75, 25, 24, 15, 12, 6 and 3. Code 7 divides by 75. One reference edge is produced on every ratio-th crystal tick.
- R2: The divider value N is written at address 0 in wr_data[15:0]. The programmable divider emits one edge on every N-th tick of the selected input. Any N below 2 is treated as 2.
- R3: A newly written N is used only from the next terminal count of the programmable divider. The period already in progress completes with the old value.
- R4: Control bits [4:3] select the band. 00 takes fm_tick and enables fm_amp_en. 10 and 01 take am_tick and enable am_amp_en, with am_hi_band set only for 10. 11 takes neither input. Ticks on an unselected input have no effect, and the two amplifier enables are never high together.
- R5: If the divided local edge leads the reference edge, the block drives pump_oe=1, pump_up=1. If the reference edge leads, it drives pump_oe=1, pump_up=0. Otherwise pump_oe=0, and pump_up is 0 whenever pump_oe is 0. Two edges in the same cycle cancel.
- R6: Control bits [6:5] select the dead zone W: codes 0..3 give 0, 1, 2 and 4 clock cycles. A lead of L clock cycles yields a pump pulse of max(L-W, 0) cycles.
- R7: unlock is set whenever a pump pulse is driven and stays set until a write to address 2 clears it. pump_oe high implies unlock high.
- R8: While pll_run is low, the pump is released and both amplifier enables are low. When pll_run returns high, both dividers restart from a full count. Register contents and unlock are kept through the stop.
- R9: After reset the pump is released, unlock is 0, all registers are 0 and the amplifier enables are low.
- R10: The pump never switches directly between high and low drive. At least one released cycle separates the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_run | input | 1 | Loop active; low releases the pump and restarts the dividers |
| xt_tick | input | 1 | One-cycle pulse per crystal period |
| fm_tick | input | 1 | One-cycle pulse per FM local-oscillator period |
| am_tick | input | 1 | One-cycle pulse per AM local-oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divider N, 1 control, 2 clear unlock |
| wr_data | input | DATA_W | Write data |
| pump_oe | output | 1 | Pump driven (0 = released / high impedance) |
| pump_up | output | 1 | Pump level when driven (1 = high) |
| unlock | output | 1 | Sticky flag: a pump pulse wider than the dead zone occurred |
| fm_amp_en | output | 1 | FM input amplifier enable |
| am_amp_en | output | 1 | AM input amplifier enable |
| am_hi_band | output | 1 | AM amplifier set to the shortwave range |

## Verification
The bench uses the default build: 16-bit data and N, and a dead-zone unit of one cycle. This keeps the four widths at 0, 1, 2 and 4 cycles. With reference code 6 (ratio 3) and N = 3, each trial needs only three ticks per input. This allows a full sweep of all lead and lag offsets from 0 to 6 cycles against every dead-zone setting, with pulse lengths predicted arithmetically. The bench also sweeps every reference code and a set of small and degenerate N values by counting ticks to the first pump edge. It covers each band's input gating, a mid-period change of N, and the stop-and-restart path.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

  typedef enum logic [1:0] {
    BAND_FM    = 2'b00,
    BAND_AM_LO = 2'b01,
    BAND_AM_HI = 2'b10,
    BAND_NONE  = 2'b11
  } band_e;

  localparam logic [1:0] ADDR_NDIV = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;

  localparam int RATIO_W = 7;

  // crystal ticks per reference edge for each rate code
  function automatic logic [RATIO_W-1:0] ref_ratio(input logic [2:0] code);
    case (code)
      3'd1:    return 7'd25;
      3'd2:    return 7'd24;
      3'd3:    return 7'd15;
      3'd4:    return 7'd12;
      3'd5:    return 7'd6;
      3'd6:    return 7'd3;
      default: return 7'd75;
    endcase
  endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
  import pll_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       xt_tick,
  input  logic [2:0] rate_code,
  output logic       ref_edge
);

  logic [RATIO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= ref_ratio(rate_code) - 7'd1;
      ref_edge <= 1'b0;
    end else begin
      ref_edge <= 1'b0;
      if (xt_tick) begin
        if (cnt == '0) begin
          ref_edge <= 1'b1;
          cnt      <= ref_ratio(rate_code) - 7'd1;
        end else begin
          cnt <= cnt - 7'd1;
        end
      end
    end
  end

endmodule

// File: rtl/pll_n_div.sv
module pll_n_div #(
  parameter int N_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           lo_tick,
  input  logic [N_W-1:0] n_val,
  output logic           div_edge
);

  localparam logic [N_W-1:0] N_MIN = N_W'(2);

  logic [N_W-1:0] cnt;
  logic [N_W-1:0] reload;

  always_comb begin
    reload = ((n_val < N_MIN) ? N_MIN : n_val) - N_W'(1);
  end

  // the reload value is sampled only at terminal count
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= reload;
      div_edge <= 1'b0;
    end else begin
      div_edge <= 1'b0;
      if (lo_tick) begin
        if (cnt == '0) begin
          div_edge <= 1'b1;
          cnt      <= reload;
        end else begin
          cnt <= cnt - N_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pll_phase_det.sv
module pll_phase_det #(
  parameter int DZ_UNIT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       ref_edge,
  input  logic       div_edge,
  input  logic [1:0] dz_sel,
  input  logic       clr_unlock,
  output logic       pump_oe,
  output logic       pump_up,
  output logic       unlock
);

  localparam int CNT_MAXI = 4 * DZ_UNIT + 1;
  localparam int CNT_W    = $clog2(CNT_MAXI + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CNT_MAXI);

  logic             hi_q, lo_q, hi_n, lo_n;
  logic [CNT_W-1:0] age_q, age_n, dz_w;
  logic             fire;

  always_comb begin
    case (dz_sel)
      2'd0:    dz_w = '0;
      2'd1:    dz_w = CNT_W'(DZ_UNIT);
      2'd2:    dz_w = CNT_W'(2 * DZ_UNIT);
      default: dz_w = CNT_W'(4 * DZ_UNIT);
    endcase
  end

  // up/down flags: set by own edge, both cleared when the other arrives
  always_comb begin
    hi_n = (hi_q | div_edge) & ~(lo_q | ref_edge);
    lo_n = (lo_q | ref_edge) & ~(hi_q | div_edge);
    if ((hi_n | lo_n) && (hi_q | lo_q))
      age_n = (age_q == CNT_MAX) ? age_q : age_q + CNT_W'(1);
    else
      age_n = '0;
    fire = (hi_n | lo_n) && (age_n >= dz_w);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      age_q   <= '0;
      pump_oe <= 1'b0;
      pump_up <= 1'b0;
    end else begin
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      age_q   <= age_n;
      pump_oe <= fire;
      pump_up <= fire & hi_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      unlock <= 1'b0;
    else
      unlock <= (run & fire) | (unlock & ~clr_unlock);
  end

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_core_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int N_W     = 16,
  parameter int DZ_UNIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_run,
  input  logic              xt_tick,
  input  logic              fm_tick,
  input  logic              am_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pump_oe,
  output logic              pump_up,
  output logic              unlock,
  output logic              fm_amp_en,
  output logic              am_amp_en,
  output logic              am_hi_band
);

  localparam int CTRL_W = 7;

  logic [N_W-1:0] n_reg;
  logic [2:0]     rate_code;
  band_e          band;
  logic [1:0]     dz_sel;
  logic           clr_unlock;
  logic           lo_tick;
  logic           ref_edge, div_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_reg     <= '0;
      rate_code <= '0;
      band      <= BAND_FM;
      dz_sel    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_NDIV)
        n_reg <= wr_data[N_W-1:0];
      if (wr_addr == ADDR_CTRL) begin
        rate_code <= wr_data[2:0];
        band      <= band_e'(wr_data[4:3]);
        dz_sel    <= wr_data[CTRL_W-1:5];
      end
    end
  end

  assign clr_unlock = wr_en && (wr_addr == ADDR_CLR);

  always_comb begin
    case (band)
      BAND_FM:               lo_tick = fm_tick;
      BAND_AM_LO, BAND_AM_HI: lo_tick = am_tick;
      default:               lo_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fm_amp_en  <= 1'b0;
      am_amp_en  <= 1'b0;
      am_hi_band <= 1'b0;
    end else begin
      fm_amp_en  <= pll_run && (band == BAND_FM);
      am_amp_en  <= pll_run && (band == BAND_AM_LO || band == BAND_AM_HI);
      am_hi_band <= pll_run && (band == BAND_AM_HI);
    end
  end

  pll_ref_div u_ref (
    .clk      (clk),
    .rst      (rst),
    .run      (pll_run),
    .xt_tick  (xt_tick),
    .rate_code(rate_code),
    .ref_edge (ref_edge)
  );

  pll_n_div #(.N_W(N_W)) u_ndiv (
    .clk     (clk),
    .rst     (rst),
    .run     (pll_run),
    .lo_tick (lo_tick),
    .n_val   (n_reg),
    .div_edge(div_edge)
  );

  pll_phase_det #(.DZ_UNIT(DZ_UNIT)) u_pd (
    .clk       (clk),
    .rst       (rst),
    .run       (pll_run),
    .ref_edge  (ref_edge),
    .div_edge  (div_edge),
    .dz_sel    (dz_sel),
    .clr_unlock(clr_unlock),
    .pump_oe   (pump_oe),
    .pump_up   (pump_up),
    .unlock    (unlock)
  );

endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       pll_run,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       pump_oe,
  input logic       pump_up,
  input logic       unlock,
  input logic       fm_amp_en,
  input logic       am_amp_en,
  input logic       am_hi_band
);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
    !pll_run |=> (!pump_oe && !fm_amp_en && !am_amp_en));

  assert_unlock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (unlock && !(wr_en && wr_addr == 2'd2)) |=> unlock);

  assert_pump_flags_R7: assert property (@(posedge clk) disable iff (rst)
    pump_oe |-> unlock);

  assert_one_path_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fm_amp_en, am_amp_en}));

  assert_hi_band_am_R4: assert property (@(posedge clk) disable iff (rst)
    am_hi_band |-> am_amp_en);

  assert_released_low_R5: assert property (@(posedge clk) disable iff (rst)
    !pump_oe |-> !pump_up);

  assert_no_flip_up_R10: assert property (@(posedge clk) disable iff (rst)
    (pump_oe && pump_up) |=> !(pump_oe && !pump_up));

  assert_no_flip_dn_R10: assert property (@(posedge clk) disable iff (rst)
    (pump_oe && !pump_up) |=> !(pump_oe && pump_up));

endmodule

bind pll_synth_core pll_synth_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pll_run   (pll_run),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .pump_oe   (pump_oe),
  .pump_up   (pump_up),
  .unlock    (unlock),
  .fm_amp_en (fm_amp_en),
  .am_amp_en (am_amp_en),
  .am_hi_band(am_hi_band)
);

// File: tb/pll_synth_core_test.sv
module pll_synth_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pll_run = 1'b0;
  logic        xt_tick = 1'b0;
  logic        fm_tick = 1'b0;
  logic        am_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pump_oe, pump_up, unlock, fm_amp_en, am_amp_en, am_hi_band;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pll_synth_core uut (
    .clk(clk), .rst(rst), .pll_run(pll_run), .xt_tick(xt_tick),
    .fm_tick(fm_tick), .am_tick(am_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pump_oe(pump_oe), .pump_up(pump_up), .unlock(unlock),
    .fm_amp_en(fm_amp_en), .am_amp_en(am_amp_en), .am_hi_band(am_hi_band)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input int code, input int band, input int dz);
    wr(2'd1, 16'((dz << 5) | (band << 3) | code));
  endtask

  task automatic restart();
    @(negedge clk); pll_run = 1'b0;
    @(negedge clk); pll_run = 1'b1;
    @(negedge clk);
  endtask

  // 0 = crystal, 1 = fm, 2 = am; leaves time for the pump to settle
  task automatic tick(input int src);
    @(negedge clk);
    xt_tick = (src == 0); fm_tick = (src == 1); am_tick = (src == 2);
    @(negedge clk);
    xt_tick = 1'b0; fm_tick = 1'b0; am_tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic int exp_ratio(input int code);
    int hz [8] = '{1000, 3000, 3125, 5000, 6250, 12500, 25000, 1000};
    return 75000 / hz[code];
  endfunction

  function automatic int dz_width(input int sel);
    return (sel == 0) ? 0 : (1 << (sel - 1));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 pump_oe", pump_oe, 0);
    check("R9 unlock", unlock, 0);
    check("R9 fm_amp_en", fm_amp_en, 0);
    check("R9 am_amp_en", am_amp_en, 0);
    pll_run = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 fm_amp_en band 00", fm_amp_en, 1);

    // R1 reference ratios: crystal ticks until the pump drives low
    for (int c = 0; c < 8; c++) begin
      pll_run = 1'b0;
      set_ctrl(c, 0, 0);
      restart();
      got = 0;
      for (int i = 1; i <= 80; i++) begin
        tick(0);
        if (pump_oe && got == 0) begin
          got = i;
          check("R1 ref edge drives low", pump_up, 0);
        end
      end
      check($sformatf("R1 ratio code %0d", c), got, exp_ratio(c));
    end

    // R2 programmable ratio including N below 2
    foreach (got_n[i]) ;
    for (int k = 0; k < 6; k++) begin
      int nv [6] = '{0, 1, 2, 3, 7, 40};
      pll_run = 1'b0;
      wr(2'd0, 16'(nv[k]));
      set_ctrl(0, 0, 0);
      restart();
      got = 0;
      for (int i = 1; i <= 45; i++) begin
        tick(1);
        if (pump_oe && got == 0) begin
          got = i;
          check("R2 local edge drives high", pump_up, 1);
        end
      end
      check($sformatf("R2 N=%0d", nv[k]), got, (nv[k] < 2) ? 2 : nv[k]);
    end

    // R4 band gating
    wr(2'd0, 16'd2);
    for (int b = 1; b < 4; b++) begin
      pll_run = 1'b0;
      set_ctrl(0, b, 0);
      restart();
      check($sformatf("R4 fm_amp_en band %0d", b), fm_amp_en, 0);
      check($sformatf("R4 am_amp_en band %0d", b), am_amp_en, (b != 3) ? 1 : 0);
      check($sformatf("R4 am_hi_band band %0d", b), am_hi_band, (b == 2) ? 1 : 0);
      repeat (4) tick(1);
      check($sformatf("R4 fm ignored band %0d", b), pump_oe, 0);
      repeat (2) tick(2);
      check($sformatf("R4 am path band %0d", b), pump_oe, (b != 3) ? 1 : 0);
    end
    pll_run = 1'b0;
    set_ctrl(0, 0, 0);
    restart();
    repeat (4) tick(2);
    check("R4 am ignored band 00", pump_oe, 0);

    // R3 N change mid-period, then R8 stop/restart
    pll_run = 1'b0;
    wr(2'd0, 16'd3);
    set_ctrl(6, 0, 0);
    restart();
    tick(1);
    wr(2'd0, 16'd5);
    tick(1);
    check("R3 no edge before old count", pump_oe, 0);
    tick(1);
    check("R3 old N completes", pump_oe, 1);
    repeat (3) tick(0);
    check("R5 ref edge releases", pump_oe, 0);
    got = 0;
    for (int i = 1; i <= 8; i++) begin
      tick(1);
      if (pump_oe && got == 0) got = i;
    end
    check("R3 new N after terminal count", got, 5);
    @(negedge clk); pll_run = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 pump released in stop", pump_oe, 0);
    check("R8 fm_amp_en off in stop", fm_amp_en, 0);
    check("R8 unlock kept", unlock, 1);
    pll_run = 1'b1;
    @(negedge clk);
    got = 0;
    for (int i = 1; i <= 8; i++) begin
      tick(1);
      if (pump_oe && got == 0) got = i;
    end
    check("R8 divider restarts full count", got, 5);
    wr(2'd2, 16'd0);
    @(negedge clk);
    check("R7 clear keeps pumping sets again", unlock, 1);

    // R5 R6 R7 sweep: lead/lag offsets against every dead zone
    for (int dz = 0; dz < 4; dz++) begin
      pll_run = 1'b0;
      wr(2'd0, 16'd3);
      set_ctrl(6, 0, dz);
      restart();
      for (int lo = 0; lo < 7; lo++) begin
        for (int xo = 0; xo < 7; xo++) begin
          int up_c, dn_c, d, w, eu, ed;
          wr(2'd2, 16'd0);
          @(negedge clk);
          check("R7 cleared", unlock, 0);
          up_c = 0; dn_c = 0;
          for (int k = 0; k <= 40; k++) begin
            @(negedge clk);
            if (pump_oe && pump_up) up_c++;
            if (pump_oe && !pump_up) dn_c++;
            fm_tick = (k == 0 || k == 2 || k == 10 + lo);
            xt_tick = (k == 1 || k == 3 || k == 10 + xo);
          end
          fm_tick = 1'b0; xt_tick = 1'b0;
          @(negedge clk);
          d = xo - lo;
          w = dz_width(dz);
          eu = (d > w) ? d - w : 0;
          ed = (-d > w) ? -d - w : 0;
          check($sformatf("R5 R6 up dz=%0d d=%0d", dz, d), up_c, eu);
          check($sformatf("R5 R6 down dz=%0d d=%0d", dz, d), dn_c, ed);
          check($sformatf("R7 unlock dz=%0d d=%0d", dz, d), unlock, (eu + ed > 0) ? 1 : 0);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int got_n [1];

endmodule